// File: doc/BRIEF.md
# Strided Block Address Generator

This block produces the address sequence for one side of a DMA transfer. A single start pulse captures a packed configuration word, a stride-enable bit, a base address and a total byte count. From the following cycle the block offers one address per beat on a valid/ready handshake, together with the size of that beat in bytes. It stops once the byte budget is used up and then raises a done flag.

Four movement modes cover the common cases: counting up through memory, counting down, holding one address for a device FIFO, and a wrapping burst that cycles inside a 32-byte window anchored at the base. When stride mode is enabled the generator instead walks forward through a block of consecutive beats, then skips a programmable gap before the next block starts. This lets one transfer gather or scatter evenly spaced records.

The address side of a channel holds one instance. The data mover consumes each offered address and raises ready when it can take the next one.

Top module: `strided_addr_gen`

## Requirements
- R1: After synchronous active-low reset, `addr_valid_o` and `done_o` are both low.
- R2: On the clock edge where `start_i` is high, the block captures its inputs. One cycle later `addr_o` equals `base_addr_i`, and `beat_bytes_o` equals 1 shifted left by the size code in configuration bits 31:30 (codes 0..3 give 1, 2, 4 and 8 bytes).
- R3: With stride mode off and movement code 0 in bits 29:28, each accepted beat adds the beat size to the address.
- R4: With stride mode off and movement code 1, each accepted beat subtracts the beat size from the address.
- R5: With stride mode off and movement code 2, the address stays at the base for every beat.
- R6: With stride mode off and movement code 3, the address is the base plus a byte offset. The offset grows by the beat size per accepted beat and wraps modulo 32.
- R7: With `stride_en_i` high, the movement code is ignored. A per-block byte counter grows by the beat size on each accepted beat. When it reaches or passes the block size in bits 27:14, the next address is the current address plus the beat size plus the stride in bits 13:0, and the counter clears. Otherwise the address advances by the beat size. A block size of 0 closes a block on every beat.
- R8: While `addr_valid_o` is high and `addr_ready_i` is low, `addr_o` and `beat_bytes_o` hold and valid stays high.
- R9: Exactly ceil(total / beat size) beats are offered. `done_o` rises on the edge that accepts the last beat, and valid and done are never high together. A total of 0 raises done one cycle after start and offers no beat.
- R10: Once done, `addr_ready_i` has no effect. Valid stays low and done stays high until the next start.
- R11: A start pulse during a running transfer abandons that transfer, and the new one begins at its own base on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Capture configuration and begin a transfer |
| cfg_word_i | input | 2*FW+4 (32) | Size code, movement code, block size, stride |
| stride_en_i | input | 1 | Selects block-plus-stride addressing |
| base_addr_i | input | AW (32) | First address of the transfer |
| total_bytes_i | input | CW (24) | Byte budget of the transfer |
| addr_valid_o | output | 1 | An address is offered |
| addr_ready_i | input | 1 | Consumer accepts the offered address |
| addr_o | output | AW (32) | Offered address |
| beat_bytes_o | output | 4 | Size of the offered beat in bytes |
| done_o | output | 1 | Byte budget used up |

## Verification
On every cycle, the assertions check the handshake hold, the exclusion of valid and done, the stickiness of done, that the beat size is one-hot, the single-beat address step in the increment, decrement and static modes, and that a burst address stays inside its window. The exact address chains can only be shown by the bench scenarios run against a reference walk: the wrap points in burst mode, the gap jumps between stride blocks, the zero-length block, the beat count for budgets that do not divide evenly, and a restart in the middle of a transfer.

// File: rtl/sbag_pkg.sv
// Package: shared types and helpers for the strided address generator.
// Assumes the size code is 2 bits wide and beats are at most 8 bytes.
package sbag_pkg;

    typedef enum logic [1:0] {
        MOVE_INC  = 2'd0,
        MOVE_DEC  = 2'd1,
        MOVE_HOLD = 2'd2,
        MOVE_WRAP = 2'd3
    } move_e;

    localparam int BEAT_W = 4;

    // Converts a size code into the beat size in bytes.
    function automatic logic [BEAT_W-1:0] beat_from_code(input logic [1:0] code);
        return BEAT_W'(1) << code;
    endfunction

endpackage

// File: rtl/sbag_cfg_reg.sv
// Module: sbag_cfg_reg
// Captures the transfer configuration on a load pulse and holds it for the
// whole transfer. It decodes the packed word into size, movement, block size
// and stride. It assumes the word layout {size[1:0], move[1:0], blk[FW-1:0],
// stride[FW-1:0]} with the most significant field first.
module sbag_cfg_reg
    import sbag_pkg::*;
#(
    parameter int AW = 32,
    parameter int FW = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [2*FW+3:0]     cfg_word_i,
    input  logic                stride_en_i,
    input  logic [AW-1:0]       base_i,
    output move_e               move_o,
    output logic [BEAT_W-1:0]   beat_o,
    output logic [FW-1:0]       blk_o,
    output logic [FW-1:0]       stride_o,
    output logic                stride_en_o,
    output logic [AW-1:0]       base_o
);

    localparam int SIZE_LSB = 2*FW + 2;
    localparam int MOVE_LSB = 2*FW;

    // Holds the decoded configuration from one start to the next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            move_o      <= MOVE_INC;
            beat_o      <= BEAT_W'(1);
            blk_o       <= '0;
            stride_o    <= '0;
            stride_en_o <= 1'b0;
            base_o      <= '0;
        end else if (load_i) begin
            move_o      <= move_e'(cfg_word_i[MOVE_LSB+1:MOVE_LSB]);
            beat_o      <= beat_from_code(cfg_word_i[SIZE_LSB+1:SIZE_LSB]);
            blk_o       <= cfg_word_i[2*FW-1:FW];
            stride_o    <= cfg_word_i[FW-1:0];
            stride_en_o <= stride_en_i;
            base_o      <= base_i;
        end
    end

endmodule

// File: rtl/sbag_step.sv
// Module: sbag_step
// Purely combinational next-address logic. From the current address, the
// burst offset and the block counter it computes their values after one
// accepted beat. It assumes BURST_BYTES is a power of two of at least 8, so
// that the offset wraps by plain truncation.
module sbag_step
    import sbag_pkg::*;
#(
    parameter int AW          = 32,
    parameter int FW          = 14,
    parameter int BURST_BYTES = 32
) (
    input  logic [AW-1:0]       addr_i,
    input  logic [AW-1:0]       base_i,
    input  logic [$clog2(BURST_BYTES)-1:0] off_i,
    input  logic [FW:0]         blk_cnt_i,
    input  move_e               move_i,
    input  logic [BEAT_W-1:0]   beat_i,
    input  logic [FW-1:0]       blk_i,
    input  logic [FW-1:0]       stride_i,
    input  logic                stride_en_i,
    output logic [AW-1:0]       addr_o,
    output logic [$clog2(BURST_BYTES)-1:0] off_o,
    output logic [FW:0]         blk_cnt_o
);

    localparam int OFF_W = $clog2(BURST_BYTES);

    logic [AW-1:0] beat_ext;
    logic [AW-1:0] stride_ext;
    logic [FW:0]   blk_sum;
    logic          blk_end;
    logic [OFF_W-1:0] off_sum;

    // Widens the operands and forms the block and burst partial sums.
    always_comb begin
        beat_ext   = AW'(beat_i);
        stride_ext = AW'(stride_i);
        blk_sum    = blk_cnt_i + (FW+1)'(beat_i);
        blk_end    = blk_sum >= {1'b0, blk_i};
        off_sum    = off_i + OFF_W'(beat_i);
    end

    // Selects the next address by addressing mode.
    always_comb begin
        addr_o    = addr_i;
        off_o     = off_i;
        blk_cnt_o = blk_cnt_i;
        if (stride_en_i) begin
            if (blk_end) begin
                addr_o    = addr_i + beat_ext + stride_ext;
                blk_cnt_o = '0;
            end else begin
                addr_o    = addr_i + beat_ext;
                blk_cnt_o = blk_sum;
            end
        end else begin
            unique case (move_i)
                MOVE_INC:  addr_o = addr_i + beat_ext;
                MOVE_DEC:  addr_o = addr_i - beat_ext;
                MOVE_HOLD: addr_o = addr_i;
                MOVE_WRAP: begin
                    off_o  = off_sum;
                    addr_o = base_i + AW'(off_sum);
                end
                default:   addr_o = addr_i;
            endcase
        end
    end

endmodule

// File: rtl/sbag_budget.sv
// Module: sbag_budget
// Tracks the remaining byte budget and owns the valid and done flags. A
// load with zero bytes goes straight to done. It assumes that fire_i is
// only high while valid_o is high.
module sbag_budget
    import sbag_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CW-1:0]     total_i,
    input  logic              fire_i,
    input  logic [BEAT_W-1:0] beat_i,
    output logic              valid_o,
    output logic              done_o,
    output logic              last_o
);

    logic [CW-1:0] rem_q;

    // Flags the final beat: what remains fits within one beat.
    always_comb last_o = rem_q <= CW'(beat_i);

    // Counts the budget down and sequences the valid and done flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            valid_o <= 1'b0;
            done_o  <= 1'b0;
        end else if (load_i) begin
            rem_q   <= total_i;
            valid_o <= total_i != '0;
            done_o  <= total_i == '0;
        end else if (fire_i) begin
            if (last_o) begin
                rem_q   <= '0;
                valid_o <= 1'b0;
                done_o  <= 1'b1;
            end else begin
                rem_q   <= rem_q - CW'(beat_i);
            end
        end
    end

endmodule

// File: rtl/strided_addr_gen.sv
// Module: strided_addr_gen (top)
// Issues one address per accepted beat for one side of a DMA transfer. It
// supports increment, decrement, static, wrapping-burst and block-plus-
// stride walks, and stops after a programmed byte count. It assumes the
// configuration inputs are valid on the start cycle only.
module strided_addr_gen
    import sbag_pkg::*;
#(
    parameter int AW          = 32,
    parameter int CW          = 24,
    parameter int FW          = 14,
    parameter int BURST_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2*FW+3:0]   cfg_word_i,
    input  logic              stride_en_i,
    input  logic [AW-1:0]     base_addr_i,
    input  logic [CW-1:0]     total_bytes_i,
    output logic              addr_valid_o,
    input  logic              addr_ready_i,
    output logic [AW-1:0]     addr_o,
    output logic [BEAT_W-1:0] beat_bytes_o,
    output logic              done_o
);

    localparam int OFF_W = $clog2(BURST_BYTES);

    move_e             move_q;
    logic [FW-1:0]     blk_q;
    logic [FW-1:0]     stride_q;
    logic              stride_en_q;
    logic [AW-1:0]     base_q;
    logic [AW-1:0]     addr_q;
    logic [OFF_W-1:0]  off_q;
    logic [FW:0]       blk_cnt_q;
    logic [AW-1:0]     addr_nxt;
    logic [OFF_W-1:0]  off_nxt;
    logic [FW:0]       blk_cnt_nxt;
    logic              fire;
    logic              last_w;

    sbag_cfg_reg #(.AW(AW), .FW(FW)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (start_i),
        .cfg_word_i  (cfg_word_i),
        .stride_en_i (stride_en_i),
        .base_i      (base_addr_i),
        .move_o      (move_q),
        .beat_o      (beat_bytes_o),
        .blk_o       (blk_q),
        .stride_o    (stride_q),
        .stride_en_o (stride_en_q),
        .base_o      (base_q)
    );

    sbag_step #(.AW(AW), .FW(FW), .BURST_BYTES(BURST_BYTES)) u_step (
        .addr_i      (addr_q),
        .base_i      (base_q),
        .off_i       (off_q),
        .blk_cnt_i   (blk_cnt_q),
        .move_i      (move_q),
        .beat_i      (beat_bytes_o),
        .blk_i       (blk_q),
        .stride_i    (stride_q),
        .stride_en_i (stride_en_q),
        .addr_o      (addr_nxt),
        .off_o       (off_nxt),
        .blk_cnt_o   (blk_cnt_nxt)
    );

    sbag_budget #(.CW(CW)) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start_i),
        .total_i (total_bytes_i),
        .fire_i  (fire),
        .beat_i  (beat_bytes_o),
        .valid_o (addr_valid_o),
        .done_o  (done_o),
        .last_o  (last_w)
    );

    // A beat is accepted only while an address is on offer.
    always_comb fire = addr_valid_o && addr_ready_i;

    // Loads the walk state on start and advances it on each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            off_q     <= '0;
            blk_cnt_q <= '0;
        end else if (start_i) begin
            addr_q    <= base_addr_i;
            off_q     <= '0;
            blk_cnt_q <= '0;
        end else if (fire) begin
            addr_q    <= addr_nxt;
            off_q     <= off_nxt;
            blk_cnt_q <= blk_cnt_nxt;
        end
    end

    // Drives the offered address from the walk register.
    always_comb addr_o = addr_q;

endmodule

// File: rtl/sbag_chk.sv
// Module: sbag_chk
// Property checker for strided_addr_gen, attached through bind. It observes
// the handshake, the outputs and the captured configuration.
module sbag_chk
    import sbag_pkg::*;
#(
    parameter int AW          = 32,
    parameter int BURST_BYTES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              valid,
    input logic              ready,
    input logic [AW-1:0]     addr,
    input logic [BEAT_W-1:0] beat,
    input logic              done,
    input logic [AW-1:0]     base,
    input move_e             move,
    input logic              sen,
    input logic              last
);

    logic          step_ok;
    logic [AW-1:0] span;

    // Marks an accepted beat that is not the last and not overlapped by start.
    always_comb step_ok = valid && ready && !last && !start;
    // Distance of the offered address from the base.
    always_comb span = addr - base;

    p_beat_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $countones(beat) == 1);

    p_inc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step_ok && !sen && move == MOVE_INC |=> addr == $past(addr) + AW'($past(beat)));

    p_dec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step_ok && !sen && move == MOVE_DEC |=> addr == $past(addr) - AW'($past(beat)));

    p_static_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_ok && !sen && move == MOVE_HOLD |=> $stable(addr));

    p_burst_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !sen && move == MOVE_WRAP |-> span < AW'(BURST_BYTES));

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready && !start |=> valid && $stable(addr) && $stable(beat));

    p_valid_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && done));

    p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && !valid);

endmodule

bind strided_addr_gen sbag_chk #(.AW(AW), .BURST_BYTES(BURST_BYTES)) i_sbag_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_i),
    .valid (addr_valid_o),
    .ready (addr_ready_i),
    .addr  (addr_o),
    .beat  (beat_bytes_o),
    .done  (done_o),
    .base  (base_q),
    .move  (move_q),
    .sen   (stride_en_q),
    .last  (last_w)
);

// File: tb/test_strided_addr_gen.sv
// Bench: drives directed and seeded random transfers and compares every
// offered address with a walk computed from the requirements.
module test_strided_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] cfg_word_i = '0;
    logic        stride_en_i = 1'b0;
    logic [31:0] base_addr_i = '0;
    logic [23:0] total_bytes_i = '0;
    logic        addr_ready_i = 1'b0;
    logic        addr_valid_o;
    logic [31:0] addr_o;
    logic [3:0]  beat_bytes_o;
    logic        done_o;

    int total = 0;
    int bad = 0;

    strided_addr_gen i_strided_addr_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .cfg_word_i    (cfg_word_i),
        .stride_en_i   (stride_en_i),
        .base_addr_i   (base_addr_i),
        .total_bytes_i (total_bytes_i),
        .addr_valid_o  (addr_valid_o),
        .addr_ready_i  (addr_ready_i),
        .addr_o        (addr_o),
        .beat_bytes_o  (beat_bytes_o),
        .done_o        (done_o)
    );

    always #5 clk = ~clk;

    // Counts one check and reports a mismatch.
    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cfg(input int sz, input int mv, input int blk, input int str);
        return {sz[1:0], mv[1:0], blk[13:0], str[13:0]};
    endfunction

    // Runs one transfer against the reference walk; stops early after
    // abort_after beats when abort_after is positive.
    task automatic run_xfer(input string req, input logic [31:0] cfg, input bit sen,
                            input logic [31:0] base, input int nbytes,
                            input int rdy_pct, input int abort_after);
        int beat;
        int mv;
        int blk_size;
        int stride;
        int rem;
        int seen;
        int cyc;
        int off;
        int blk;
        int exp_beats;
        bit rdy;
        logic [31:0] ea;
        beat     = 1 << cfg[31:30];
        mv       = int'(cfg[29:28]);
        blk_size = int'(cfg[27:14]);
        stride   = int'(cfg[13:0]);
        @(negedge clk);
        cfg_word_i    = cfg;
        stride_en_i   = sen;
        base_addr_i   = base;
        total_bytes_i = 24'(nbytes);
        addr_ready_i  = 1'b0;
        start_i       = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        ea = base; off = 0; blk = 0; rem = nbytes; seen = 0; cyc = 0;
        exp_beats = (nbytes + beat - 1) / beat;
        if (nbytes == 0) begin
            chk({req, " R9 zero-length done"}, 64'(done_o), 64'd1);
            chk({req, " R9 zero-length valid"}, 64'(addr_valid_o), 64'd0);
        end
        while (rem > 0 && cyc < 4000) begin
            if (abort_after > 0 && seen == abort_after) return;
            chk({req, " valid"}, 64'(addr_valid_o), 64'd1);
            chk({req, " addr"}, 64'(addr_o), 64'(ea));
            chk({req, " R2 beat"}, 64'(beat_bytes_o), 64'(beat));
            rdy = ($urandom % 100) < rdy_pct;
            addr_ready_i = rdy;
            @(negedge clk);
            cyc++;
            if (rdy) begin
                seen++;
                rem -= beat;
                if (sen) begin
                    if (blk + beat >= blk_size) begin
                        ea  = ea + 32'(beat) + 32'(stride);
                        blk = 0;
                    end else begin
                        ea  = ea + 32'(beat);
                        blk = blk + beat;
                    end
                end else begin
                    case (mv)
                        0: ea = ea + 32'(beat);
                        1: ea = ea - 32'(beat);
                        2: ea = ea;
                        default: begin
                            off = (off + beat) % 32;
                            ea  = base + 32'(off);
                        end
                    endcase
                end
            end
        end
        addr_ready_i = 1'b0;
        chk({req, " R9 beat count"}, 64'(seen), 64'(exp_beats));
        chk({req, " R9 done"}, 64'(done_o), 64'd1);
        chk({req, " R9 valid low"}, 64'(addr_valid_o), 64'd0);
    endtask

    // Pushes ready after completion and confirms nothing moves.
    task automatic poke_after_done();
        logic [31:0] a0;
        a0 = addr_o;
        addr_ready_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10 done held", 64'(done_o), 64'd1);
            chk("R10 valid low", 64'(addr_valid_o), 64'd0);
            chk("R10 addr unchanged", 64'(addr_o), 64'(a0));
        end
        addr_ready_i = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", 64'(addr_valid_o), 64'd0);
        chk("R1 done after reset", 64'(done_o), 64'd0);

        run_xfer("R3 inc word", mk_cfg(2, 0, 0, 0), 1'b0, 32'h1000, 16, 100, 0);
        poke_after_done();
        run_xfer("R4 dec half", mk_cfg(1, 1, 0, 0), 1'b0, 32'h2000, 10, 60, 0);
        run_xfer("R5 static byte", mk_cfg(0, 2, 0, 0), 1'b0, 32'h3003, 7, 50, 0);
        run_xfer("R6 burst dword", mk_cfg(3, 3, 0, 0), 1'b0, 32'h4000, 80, 70, 0);
        run_xfer("R6 burst word", mk_cfg(2, 3, 0, 0), 1'b0, 32'h5010, 100, 100, 0);
        run_xfer("R7 stride blk8", mk_cfg(2, 1, 8, 16), 1'b1, 32'h6000, 32, 80, 0);
        run_xfer("R7 stride blk0", mk_cfg(1, 2, 0, 6), 1'b1, 32'h7000, 12, 100, 0);
        run_xfer("R8 stall heavy", mk_cfg(2, 0, 0, 0), 1'b0, 32'h8000, 24, 20, 0);
        run_xfer("R9 odd total", mk_cfg(2, 0, 0, 0), 1'b0, 32'h9000, 5, 100, 0);
        run_xfer("R9 zero total", mk_cfg(2, 0, 0, 0), 1'b0, 32'hA000, 0, 100, 0);
        poke_after_done();
        run_xfer("R11 first", mk_cfg(2, 0, 0, 0), 1'b0, 32'hB000, 64, 100, 3);
        run_xfer("R11 restart", mk_cfg(0, 1, 0, 0), 1'b0, 32'hC000, 6, 100, 0);

        for (int n = 0; n < 40; n++) begin
            int sz;
            int mv;
            int blk_size;
            int stride;
            int nb;
            bit sen;
            sz       = int'($urandom % 4);
            mv       = int'($urandom % 4);
            blk_size = int'($urandom % 40);
            stride   = int'($urandom % 100);
            nb       = int'($urandom % 120);
            sen      = 1'($urandom % 2);
            run_xfer(sen ? "R7 random" : "R3-R6 random",
                     mk_cfg(sz, mv, blk_size, stride), sen, $urandom, nb,
                     30 + int'($urandom % 70), 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Ends a hung run as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule